// File: doc/BRIEF.md
# Oversampled Serial Receiver with Multidrop Address Filter

This block receives asynchronous serial frames on a single input line. A programmable divider produces an oversampling tick at sixteen times the bit rate. A front end that runs on that tick finds each start bit, checks it at mid-bit, and takes every data bit as a three-sample majority vote near the centre of the bit. Frames carry eight data bits, least significant bit first. An optional ninth bit can follow them, and a stop bit ends the frame.

Each accepted frame goes into a two-entry receive queue. An entry holds the data byte, the ninth bit and a framing-error bit, so the status for the oldest byte is visible at the same time as the byte. A read strobe pops the queue. A pending-data flag, and an interrupt gated by an enable, tell the host that data is waiting. For multidrop buses the block can run with address filtering: in nine-bit mode, frames whose ninth bit is clear are then thrown away. When a frame arrives while the queue is full, an overrun flag is set. That flag blocks further storage until the receive enable is dropped.

Top module: `uart_addr_rx`

## Requirements
- R1: After reset `rx_avail`, `irq` and `ovr_err` are 0.
- R2: An eight-bit frame sent LSB first with a high stop bit appears on `rd_data` with `rd_ferr`=0 and `rd_bit8`=0, and `rx_avail` is 1 while it waits.
- R3: With `nine_bit_en`=1 the bit after data bit 7 is captured, and it is shown on `rd_bit8` together with its byte at the queue head.
- R4: With `nine_bit_en`=1 and `addr_det_en`=1, a frame whose ninth bit is 0 is discarded and leaves `rx_avail` at 0. A frame whose ninth bit is 1 is stored.
- R5: A frame whose stop bit is sampled low is stored with `rd_ferr`=1.
- R6: A frame that completes while both queue entries are occupied is not stored and sets `ovr_err`. The two older entries remain readable in arrival order.
- R7: While `ovr_err` is 1, later frames are not stored. Driving `rx_en` (or `port_en`) to 0 clears `ovr_err`.
- R8: `irq` is 1 exactly when `rx_avail` and `irq_en` are both 1.
- R9: With `port_en`=0 or `rx_en`=0, frames on `rxd` are ignored.
- R10: A low pulse on an idle line that is shorter than half a bit is rejected as a false start and stores nothing.
- R11: One bit lasts (`div_val`+1)*16 clock cycles when `fast_sel`=1 and (`div_val`+1)*64 when `fast_sel`=0.
- R12: A one-cycle `rd_pop` while `rx_avail`=1 removes the head entry, and `rx_avail` returns to 0 once the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Serial port enable |
| rx_en | input | 1 | Continuous receive enable; a low level clears overrun and restarts the receiver |
| nine_bit_en | input | 1 | Enables nine-bit frames |
| addr_det_en | input | 1 | Address filter (applies only in nine-bit mode) |
| fast_sel | input | 1 | 1: bit period is 16 divider periods; 0: 64 divider periods |
| div_val | input | DIV_W | Divider value; each divider period is div_val+1 clocks |
| irq_en | input | 1 | Interrupt enable |
| rxd | input | 1 | Serial input line (idle high) |
| rd_pop | input | 1 | Pops the queue head |
| rd_data | output | 8 | Data byte at the queue head |
| rd_bit8 | output | 1 | Ninth bit of the queue head |
| rd_ferr | output | 1 | Framing error of the queue head |
| rx_avail | output | 1 | Queue holds unread data |
| irq | output | 1 | Masked receive interrupt |
| ovr_err | output | 1 | Overrun error |

## Verification
The properties assume that the filter and frame-length settings do not change between a frame's completion and the following clock cycle. They also assume that a pop is never issued in the same cycle as a frame completing into a full queue. The stimulus keeps to this: configuration is changed only while the line has been idle for at least one bit time. During the overrun scenario the read side stays quiet until every frame has been sent. Each frame is driven at exactly the bit period that the current divider and speed select imply, with its edges placed on the falling clock edge.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int OS_RATE     = 16;
    localparam int OS_W        = $clog2(OS_RATE);
    localparam int SLOW_FACTOR = 4;
    localparam int SLOW_W      = $clog2(SLOW_FACTOR);
    localparam int MID_A       = 7;
    localparam int MID_B       = 8;
    localparam int MID_C       = 9;

    typedef struct packed {
        logic [7:0] data;
        logic       bit8;
        logic       ferr;
    } rx_word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_NINTH,
        ST_STOP
    } rx_state_e;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/rx_baud_gen.sv
module rx_baud_gen
    import uart_rx_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             fast_sel,
    input  logic [DIV_W-1:0] div_val,
    output logic             os_tick
);
    logic [DIV_W-1:0]  pre_q;
    logic [SLOW_W-1:0] slow_q;
    logic              step;

    assign step = run && (pre_q == div_val);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_q  <= '0;
            slow_q <= '0;
        end else if (step) begin
            pre_q  <= '0;
            slow_q <= slow_q + 1'b1;
        end else begin
            pre_q  <= pre_q + 1'b1;
        end
    end

    assign os_tick = step && (fast_sel || (slow_q == SLOW_W'(SLOW_FACTOR - 1)));

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import uart_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  logic     os_tick,
    input  logic     rxd_s,
    input  logic     nine_bit_en,
    output logic     done,
    output rx_word_t word
);
    rx_state_e       state_q;
    logic [OS_W-1:0] tick_q;
    logic [2:0]      idx_q;
    logic            smp_a, smp_b;
    logic [7:0]      shreg_q;
    logic            b8_q;
    logic            vote;

    assign vote = vote3(smp_a, smp_b, rxd_s);

    always_ff @(posedge clk) begin
        done <= 1'b0;
        if (rst || !run) begin
            state_q <= ST_IDLE;
            tick_q  <= '0;
            idx_q   <= '0;
            smp_a   <= 1'b1;
            smp_b   <= 1'b1;
            shreg_q <= '0;
            b8_q    <= 1'b0;
            if (rst) word <= '0;
        end else if (os_tick) begin
            if (state_q == ST_IDLE) begin
                if (!rxd_s) begin
                    state_q <= ST_START;
                    tick_q  <= '0;
                    idx_q   <= '0;
                    b8_q    <= 1'b0;
                end
            end else begin
                tick_q <= tick_q + 1'b1;
                if (tick_q == OS_W'(MID_A)) smp_a <= rxd_s;
                if (tick_q == OS_W'(MID_B)) smp_b <= rxd_s;
                if (tick_q == OS_W'(MID_C)) begin
                    case (state_q)
                        ST_START: if (vote) state_q <= ST_IDLE;
                        ST_DATA:  shreg_q <= {vote, shreg_q[7:1]};
                        ST_NINTH: b8_q <= vote;
                        ST_STOP: begin
                            word.data <= shreg_q;
                            word.bit8 <= nine_bit_en & b8_q;
                            word.ferr <= ~vote;
                            done      <= 1'b1;
                            state_q   <= ST_IDLE;
                        end
                        default: state_q <= ST_IDLE;
                    endcase
                end
                if (tick_q == OS_W'(OS_RATE - 1)) begin
                    case (state_q)
                        ST_START: state_q <= ST_DATA;
                        ST_DATA: begin
                            if (idx_q == 3'd7)
                                state_q <= nine_bit_en ? ST_NINTH : ST_STOP;
                            idx_q <= idx_q + 1'b1;
                        end
                        ST_NINTH: state_q <= ST_STOP;
                        default:  state_q <= state_q;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  rx_word_t wdata,
    input  logic     pop,
    output rx_word_t rdata,
    output logic     empty,
    output logic     full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    rx_word_t         mem [DEPTH];
    logic [PTR_W-1:0] wp_q, rp_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp_q];

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (do_push) begin
                mem[wp_q] <= wdata;
                wp_q      <= nxt(wp_q);
            end
            if (do_pop) rp_q <= nxt(rp_q);
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx
    import uart_rx_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             port_en,
    input  logic             rx_en,
    input  logic             nine_bit_en,
    input  logic             addr_det_en,
    input  logic             fast_sel,
    input  logic [DIV_W-1:0] div_val,
    input  logic             irq_en,
    input  logic             rxd,
    input  logic             rd_pop,
    output logic [7:0]       rd_data,
    output logic             rd_bit8,
    output logic             rd_ferr,
    output logic             rx_avail,
    output logic             irq,
    output logic             ovr_err
);
    logic     active;
    logic     rxd_m, rxd_s;
    logic     os_tick;
    logic     frm_done;
    rx_word_t frm_word, head;
    logic     fifo_empty, fifo_full;
    logic     keep, push;

    assign active = port_en & rx_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            rxd_m <= 1'b1;
            rxd_s <= 1'b1;
        end else begin
            rxd_m <= rxd;
            rxd_s <= rxd_m;
        end
    end

    rx_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst(rst), .run(active), .fast_sel(fast_sel),
        .div_val(div_val), .os_tick(os_tick)
    );

    rx_frame_fsm u_fsm (
        .clk(clk), .rst(rst), .run(active), .os_tick(os_tick), .rxd_s(rxd_s),
        .nine_bit_en(nine_bit_en), .done(frm_done), .word(frm_word)
    );

    assign keep = active && frm_done &&
                  (!(nine_bit_en && addr_det_en) || frm_word.bit8);
    assign push = keep && !ovr_err && !fifo_full;

    always_ff @(posedge clk) begin
        if (rst || !active)                     ovr_err <= 1'b0;
        else if (keep && !ovr_err && fifo_full) ovr_err <= 1'b1;
    end

    rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(push), .wdata(frm_word),
        .pop(rd_pop), .rdata(head), .empty(fifo_empty), .full(fifo_full)
    );

    assign rd_data  = head.data;
    assign rd_bit8  = head.bit8;
    assign rd_ferr  = head.ferr;
    assign rx_avail = !fifo_empty;
    assign irq      = rx_avail & irq_en;

endmodule

// File: rtl/uart_addr_rx_chk.sv
module uart_addr_rx_chk (
    input logic clk,
    input logic rst,
    input logic port_en,
    input logic rx_en,
    input logic nine_bit_en,
    input logic addr_det_en,
    input logic irq_en,
    input logic rx_avail,
    input logic irq,
    input logic ovr_err,
    input logic rd_bit8,
    input logic fifo_full
);
    p_ovr_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (ovr_err && port_en && rx_en) |=> ovr_err)
        else $error("R7 overrun dropped while receiver active");

    p_ovr_clear_r7: assert property (@(posedge clk) disable iff (rst)
        !(port_en && rx_en) |=> !ovr_err)
        else $error("R7 overrun not cleared by disable");

    p_ovr_when_full_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_err) |-> $past(fifo_full))
        else $error("R6 overrun raised with space in queue");

    p_addr_filter_r4: assert property (@(posedge clk) disable iff (rst)
        ($rose(rx_avail) && $past(nine_bit_en && addr_det_en)) |-> rd_bit8)
        else $error("R4 data frame passed address filter");

    p_store_needs_enable_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_avail) |-> $past(port_en && rx_en))
        else $error("R9 frame stored while disabled");

    p_irq_mask_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> (irq_en && rx_avail))
        else $error("R8 interrupt without enable or data");

endmodule

bind uart_addr_rx uart_addr_rx_chk u_chk (
    .clk(clk), .rst(rst), .port_en(port_en), .rx_en(rx_en),
    .nine_bit_en(nine_bit_en), .addr_det_en(addr_det_en), .irq_en(irq_en),
    .rx_avail(rx_avail), .irq(irq), .ovr_err(ovr_err), .rd_bit8(rd_bit8),
    .fifo_full(fifo_full)
);

// File: tb/uart_addr_rx_bench.sv
module uart_addr_rx_bench;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             port_en = 1'b0, rx_en = 1'b0;
    logic             nine_bit_en = 1'b0, addr_det_en = 1'b0;
    logic             fast_sel = 1'b1;
    logic [DIV_W-1:0] div_val = 8'd1;
    logic             irq_en = 1'b0;
    logic             rxd = 1'b1;
    logic             rd_pop = 1'b0;
    logic [7:0]       rd_data;
    logic             rd_bit8, rd_ferr, rx_avail, irq, ovr_err;

    int n_checks = 0;
    int n_errors = 0;
    int bclk = 32;
    logic mon_on = 1'b0;
    logic [9:0] exp_q[$];

    always #2 clk = ~clk;

    uart_addr_rx #(.DIV_W(DIV_W), .DEPTH(2)) u_uart_addr_rx (
        .clk(clk), .rst(rst), .port_en(port_en), .rx_en(rx_en),
        .nine_bit_en(nine_bit_en), .addr_det_en(addr_det_en), .fast_sel(fast_sel),
        .div_val(div_val), .irq_en(irq_en), .rxd(rxd), .rd_pop(rd_pop),
        .rd_data(rd_data), .rd_bit8(rd_bit8), .rd_ferr(rd_ferr),
        .rx_avail(rx_avail), .irq(irq), .ovr_err(ovr_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic b8, input logic stopv);
        rxd = 1'b0;
        wait_clk(bclk);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            wait_clk(bclk);
        end
        if (nine_bit_en) begin
            rxd = b8;
            wait_clk(bclk);
        end
        rxd = stopv;
        wait_clk(bclk);
        rxd = 1'b1;
        wait_clk(2 * bclk);
    endtask

    task automatic expect_word(input logic [7:0] d, input logic b8, input logic fe);
        exp_q.push_back({d, b8, fe});
    endtask

    // Monitor: compares the queue head against the scoreboard and pops (R12, R2, R3, R5)
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on && rx_avail) begin
                if (exp_q.size() == 0) begin
                    check("R4/R9 unexpected entry", {22'd0, rd_data, rd_bit8, rd_ferr}, 32'h3ff);
                end else begin
                    logic [9:0] e;
                    e = exp_q.pop_front();
                    check("R2 data",  {24'd0, rd_data}, {24'd0, e[9:2]});
                    check("R3 bit8",  {31'd0, rd_bit8}, {31'd0, e[1]});
                    check("R5 ferr",  {31'd0, rd_ferr}, {31'd0, e[0]});
                end
                rd_pop = 1'b1;
                @(negedge clk);
                rd_pop = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(1);
        check("R1 avail", {31'd0, rx_avail}, 0);
        check("R1 irq",   {31'd0, irq}, 0);
        check("R1 ovr",   {31'd0, ovr_err}, 0);

        port_en = 1'b1; rx_en = 1'b1; mon_on = 1'b1;
        wait_clk(bclk);

        // R2, R11: eight-bit frames at fast rate, div 1 -> 32 clocks per bit
        expect_word(8'hA5, 0, 0); send_frame(8'hA5, 0, 1);
        expect_word(8'h3C, 0, 0); send_frame(8'h3C, 0, 1);
        expect_word(8'h01, 0, 0); send_frame(8'h01, 0, 1);
        expect_word(8'hFF, 0, 0); send_frame(8'hFF, 0, 1);

        // R3: nine-bit frames
        nine_bit_en = 1'b1;
        wait_clk(bclk);
        expect_word(8'h55, 1, 0); send_frame(8'h55, 1, 1);
        expect_word(8'h12, 0, 0); send_frame(8'h12, 0, 1);

        // R4: address filter
        addr_det_en = 1'b1;
        wait_clk(bclk);
        send_frame(8'h77, 0, 1);
        check("R4 drop", {31'd0, rx_avail}, 0);
        expect_word(8'h88, 1, 0); send_frame(8'h88, 1, 1);
        addr_det_en = 1'b0; nine_bit_en = 1'b0;
        wait_clk(bclk);

        // R5: stop bit low
        expect_word(8'h5A, 0, 1); send_frame(8'h5A, 0, 0);
        wait_clk(2 * bclk);

        // R10: glitch shorter than half a bit
        rxd = 1'b0; wait_clk(8); rxd = 1'b1;
        wait_clk(3 * bclk);
        check("R10 false start", {31'd0, rx_avail}, 0);

        // R8: interrupt masking
        mon_on = 1'b0;
        wait_clk(4);
        expect_word(8'h42, 0, 0); send_frame(8'h42, 0, 1);
        check("R8 avail", {31'd0, rx_avail}, 1);
        check("R8 irq masked", {31'd0, irq}, 0);
        irq_en = 1'b1; wait_clk(1);
        check("R8 irq on", {31'd0, irq}, 1);
        mon_on = 1'b1;
        wait_clk(6);
        check("R8 irq off after drain", {31'd0, irq}, 0);
        irq_en = 1'b0;

        // R6, R7: overrun
        mon_on = 1'b0;
        wait_clk(4);
        expect_word(8'h10, 0, 0); send_frame(8'h10, 0, 1);
        expect_word(8'h20, 0, 0); send_frame(8'h20, 0, 1);
        check("R6 no ovr yet", {31'd0, ovr_err}, 0);
        send_frame(8'h30, 0, 1);
        check("R6 ovr set", {31'd0, ovr_err}, 1);
        send_frame(8'h40, 0, 1);
        check("R7 ovr held", {31'd0, ovr_err}, 1);
        mon_on = 1'b1;
        wait_clk(10);
        check("R7 blocked while ovr", {31'd0, rx_avail}, 0);
        send_frame(8'h50, 0, 1);
        check("R7 still blocked", {31'd0, rx_avail}, 0);
        rx_en = 1'b0; wait_clk(3);
        check("R7 ovr cleared", {31'd0, ovr_err}, 0);
        rx_en = 1'b1; wait_clk(bclk);

        // R9: disabled port ignores frames
        port_en = 1'b0; wait_clk(2);
        send_frame(8'h66, 0, 1);
        check("R9 ignored", {31'd0, rx_avail}, 0);
        port_en = 1'b1; rx_en = 1'b0; wait_clk(2);
        send_frame(8'h67, 0, 1);
        check("R9 ignored rx_en", {31'd0, rx_avail}, 0);
        rx_en = 1'b1; wait_clk(bclk);

        // R11: slow rate, div 0 -> 64 clocks per bit
        fast_sel = 1'b0; div_val = 8'd0; bclk = 64;
        wait_clk(bclk);
        expect_word(8'hC3, 0, 0); send_frame(8'hC3, 0, 1);
        nine_bit_en = 1'b1; wait_clk(bclk);
        expect_word(8'h9E, 1, 0); send_frame(8'h9E, 1, 1);

        // R12: everything drained
        wait_clk(10);
        check("R12 empty", {31'd0, rx_avail}, 0);
        check("R12 scoreboard drained", exp_q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule